// File: doc/BRIEF.md
# Asynchronous Exception Router

This unit sits between the pending physical asynchronous exception lines of a processor core (normal interrupt, fast interrupt and system error) and the logic that takes exceptions. In every cycle it works out which exception level each pending class would be delivered to. It then decides whether that class may be taken now, must stay pending, or belongs to a state combination that cannot exist. It reports one winner per cycle through registered outputs.

The routing step is a computed 64-entry lookup. It is indexed by the class's top-level routing bit, the lower-level width bit, the class's hypervisor routing bit, the security state and the current level. The lookup inputs are first adjusted for the implemented levels, for the trap-all-to-hypervisor control and for a narrow (32-bit) top level. A masking stage then compares the target level with the current level and with the processor-state mask bit of the class. Each class produces one verdict: idle, pending, take or impossible. Among the classes that can be taken, the system error class has the highest priority, then the fast interrupt, then the normal interrupt.

Top module: `async_exc_router`

## Requirements
- R1: Each class uses its own routing pair. The normal interrupt uses `top_rt_irq`/`hyp_rt_irq`, the fast interrupt uses `top_rt_fiq`/`hyp_rt_fiq`, and the system error uses `top_rt_ser`/`hyp_rt_ser`. The bits of the other classes have no effect on a class.
- R2: When the class's effective top-level routing bit is 1, the target is level 3 from every legal source level, in both security states.
- R3: When the top-level bit is 0 and the effective hypervisor bit is 1, a non-secure source at level 0, 1 or 2 targets level 2.
- R4: When both bits are 0, a non-secure source at level 0 or 1 targets level 1. A non-secure level-2 source targets level 2 when `lower_wide` is 0. It targets level 1 when `lower_wide` is 1, so the request stays pending.
- R5: When the top-level bit is 0, a secure source at level 0 or 1 targets level 1. A secure level-3 source also looks up level 1 and stays pending, unless R8 applies.
- R6: A secure source at level 2 or a non-secure source at level 3 is impossible. While any request is pending in such a state, `bad_combo` is 1 one cycle later and `take_o` is 0.
- R7: `hyp_trap_all` forces the hypervisor bit to 1 for the lookup. `has_lvl2`=0 forces all hypervisor bits to 0. `has_lvl3`=0 forces all top-level bits to 0.
- R8: When `has_lvl3`=1 and `top_wide`=0, `lower_wide` is treated as 0, and a secure source whose looked-up target is level 1 goes to level 3 instead.
- R9: Masking, in order. A target below the current level is not taken. A target above both the current level and level 1 is taken whatever the mask bit. Otherwise the class is taken only when its mask bit is 0.
- R10: When several classes can be taken in the same cycle, system error beats fast interrupt, and fast interrupt beats normal interrupt. Only one class is reported.
- R11: Outputs are registered with one cycle of latency. Class encoding: 00 none, 01 normal interrupt, 10 fast interrupt, 11 system error. Levels are 2-bit numbers. While `rst_n` is low at a clock edge, all outputs become 0. With no take, `take_cls` and `take_lvl` are 00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_irq | input | 1 | Normal interrupt pending |
| req_fiq | input | 1 | Fast interrupt pending |
| req_ser | input | 1 | System error pending |
| cur_lvl | input | 2 | Current exception level |
| in_secure | input | 1 | 1 when executing in the secure state |
| has_lvl2 | input | 1 | Hypervisor level implemented |
| has_lvl3 | input | 1 | Top (monitor) level implemented |
| top_wide | input | 1 | Top level runs in 64-bit state |
| top_rt_irq | input | 1 | Top-level routing bit, normal interrupt |
| top_rt_fiq | input | 1 | Top-level routing bit, fast interrupt |
| top_rt_ser | input | 1 | Top-level routing bit, system error |
| lower_wide | input | 1 | Next lower level runs in 64-bit state |
| hyp_rt_irq | input | 1 | Hypervisor routing bit, normal interrupt |
| hyp_rt_fiq | input | 1 | Hypervisor routing bit, fast interrupt |
| hyp_rt_ser | input | 1 | Hypervisor routing bit, system error |
| hyp_trap_all | input | 1 | Route everything bound for level 1 to the hypervisor |
| msk_irq | input | 1 | Processor-state mask, normal interrupt |
| msk_fiq | input | 1 | Processor-state mask, fast interrupt |
| msk_ser | input | 1 | Processor-state mask, system error |
| take_o | output | 1 | A class is taken this cycle |
| take_cls | output | 2 | Class taken (00 none) |
| take_lvl | output | 2 | Target level of the taken class |
| bad_combo | output | 1 | Pending request in an impossible state |

## Verification
The bench sweeps every single-class input combination, including absent levels, a narrow top level and the trap-all control. It then sweeps every mix of pending lines, masks, routing bits, levels and security states with a full configuration. The sweeps go after five corner cases. The first is the non-secure level-2 source with both routing bits clear: a design that ignored the width bit there would take an interrupt that must stay pending. The second is the secure level-3 source: a design missing the narrow-top redirect would leave the request stuck instead of delivering it at level 3. The third is the trap-all control: if it were applied without checking for a hypervisor level, requests would go to a level that does not exist. The fourth is the mask-bypass rule for targets above level 1: getting it wrong drops requests that should be taken, or takes requests that are masked. The fifth is the class priority and the impossible-state flag: a wrong design reports the wrong class, or takes a request in a state that cannot exist.

// File: rtl/excr_pkg.sv
package excr_pkg;
    localparam int LVL_W   = 2;
    localparam int NUM_CLS = 3;
    localparam int IDX_W   = 6;
    localparam int TAB_N   = 1 << IDX_W;
    localparam int CODE_W  = 3;
    localparam logic [CODE_W-1:0] CODE_NONE = 3'd4;

    typedef enum logic [1:0] {
        CLS_NONE = 2'b00,
        CLS_IRQ  = 2'b01,
        CLS_FIQ  = 2'b10,
        CLS_SER  = 2'b11
    } exc_cls_e;

    typedef enum logic [1:0] {
        VD_IDLE = 2'b00,
        VD_PEND = 2'b01,
        VD_TAKE = 2'b10,
        VD_BAD  = 2'b11
    } verdict_e;

    // index = {top_rt, lower_wide, hyp_rt, secure, cur[1:0]}
    function automatic logic [TAB_N-1:0][CODE_W-1:0] build_route_tab();
        logic [TAB_N-1:0][CODE_W-1:0] t;
        for (int i = 0; i < TAB_N; i++) begin
            logic [1:0] lv;
            logic sc, hr, rw, tr;
            lv = i[1:0];
            sc = i[2];
            hr = i[3];
            rw = i[4];
            tr = i[5];
            if ((sc && lv == 2'd2) || (!sc && lv == 2'd3))
                t[i] = CODE_NONE;
            else if (tr)
                t[i] = 3'd3;
            else if (sc)
                t[i] = 3'd1;
            else if (hr)
                t[i] = 3'd2;
            else if (lv == 2'd2)
                t[i] = rw ? 3'd1 : 3'd2;
            else
                t[i] = 3'd1;
        end
        return t;
    endfunction
endpackage

// File: rtl/excr_route_lut.sv
module excr_route_lut
    import excr_pkg::*;
(
    input  logic             top_rt,
    input  logic             hyp_rt,
    input  logic             lower_wide,
    input  logic             secure,
    input  logic [LVL_W-1:0] cur,
    input  logic             narrow_top,
    output logic [LVL_W-1:0] tgt,
    output logic             bad
);
    localparam logic [TAB_N-1:0][CODE_W-1:0] ROUTE_TAB = build_route_tab();

    logic [IDX_W-1:0]  idx;
    logic [CODE_W-1:0] code;

    assign idx  = {top_rt, lower_wide, hyp_rt, secure, cur};
    assign code = ROUTE_TAB[idx];

    always_comb begin
        bad = (code == CODE_NONE);
        tgt = code[LVL_W-1:0];
        if (bad)
            tgt = '0;
        else if (narrow_top && secure && tgt == 2'd1)
            tgt = 2'd3;
    end
endmodule

// File: rtl/excr_mask_gate.sv
module excr_mask_gate
    import excr_pkg::*;
(
    input  logic             pend,
    input  logic [LVL_W-1:0] cur,
    input  logic [LVL_W-1:0] tgt,
    input  logic             bad,
    input  logic             masked,
    output verdict_e         verdict
);
    always_comb begin
        if (!pend)
            verdict = VD_IDLE;
        else if (bad)
            verdict = VD_BAD;
        else if (tgt < cur)
            verdict = VD_PEND;
        else if (tgt > cur && tgt > 2'd1)
            verdict = VD_TAKE;
        else if (masked)
            verdict = VD_PEND;
        else
            verdict = VD_TAKE;
    end
endmodule

// File: rtl/async_exc_router.sv
module async_exc_router
    import excr_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_irq,
    input  logic             req_fiq,
    input  logic             req_ser,
    input  logic [LVL_W-1:0] cur_lvl,
    input  logic             in_secure,
    input  logic             has_lvl2,
    input  logic             has_lvl3,
    input  logic             top_wide,
    input  logic             top_rt_irq,
    input  logic             top_rt_fiq,
    input  logic             top_rt_ser,
    input  logic             lower_wide,
    input  logic             hyp_rt_irq,
    input  logic             hyp_rt_fiq,
    input  logic             hyp_rt_ser,
    input  logic             hyp_trap_all,
    input  logic             msk_irq,
    input  logic             msk_fiq,
    input  logic             msk_ser,
    output logic             take_o,
    output logic [1:0]       take_cls,
    output logic [LVL_W-1:0] take_lvl,
    output logic             bad_combo
);
    logic [NUM_CLS-1:0] pend_v, top_v, hyp_v, msk_v, bad_c;
    logic [LVL_W-1:0]   tgt_c [NUM_CLS];
    verdict_e           vd_c  [NUM_CLS];
    logic               narrow_top, rw_eff;

    assign pend_v = {req_ser, req_fiq, req_irq};
    assign top_v  = {top_rt_ser, top_rt_fiq, top_rt_irq};
    assign hyp_v  = {hyp_rt_ser, hyp_rt_fiq, hyp_rt_irq};
    assign msk_v  = {msk_ser, msk_fiq, msk_irq};

    assign narrow_top = has_lvl3 & ~top_wide;
    assign rw_eff     = lower_wide & ~narrow_top;

    for (genvar c = 0; c < NUM_CLS; c++) begin : g_cls
        logic top_eff, hyp_eff;
        assign top_eff = top_v[c] & has_lvl3;
        assign hyp_eff = (hyp_v[c] | hyp_trap_all) & has_lvl2;

        excr_route_lut u_lut (
            .top_rt    (top_eff),
            .hyp_rt    (hyp_eff),
            .lower_wide(rw_eff),
            .secure    (in_secure),
            .cur       (cur_lvl),
            .narrow_top(narrow_top),
            .tgt       (tgt_c[c]),
            .bad       (bad_c[c])
        );

        excr_mask_gate u_gate (
            .pend   (pend_v[c]),
            .cur    (cur_lvl),
            .tgt    (tgt_c[c]),
            .bad    (bad_c[c]),
            .masked (msk_v[c]),
            .verdict(vd_c[c])
        );
    end

    exc_cls_e         pick_cls;
    logic [LVL_W-1:0] pick_lvl;
    logic             pick_bad;

    // later (higher) classes overwrite earlier ones: SError > FIQ > IRQ
    always_comb begin
        pick_cls = CLS_NONE;
        pick_lvl = '0;
        pick_bad = 1'b0;
        for (int c = 0; c < NUM_CLS; c++) begin
            if (vd_c[c] == VD_TAKE) begin
                pick_cls = exc_cls_e'(c + 1);
                pick_lvl = tgt_c[c];
            end
            if (vd_c[c] == VD_BAD)
                pick_bad = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            take_o    <= 1'b0;
            take_cls  <= CLS_NONE;
            take_lvl  <= '0;
            bad_combo <= 1'b0;
        end else begin
            take_o    <= (pick_cls != CLS_NONE);
            take_cls  <= pick_cls;
            take_lvl  <= pick_lvl;
            bad_combo <= pick_bad;
        end
    end
endmodule

// File: rtl/async_exc_router_chk.sv
module async_exc_router_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       req_irq,
    input logic       req_fiq,
    input logic       req_ser,
    input logic [1:0] cur_lvl,
    input logic       in_secure,
    input logic       has_lvl3,
    input logic       top_wide,
    input logic       top_rt_irq,
    input logic       take_o,
    input logic [1:0] take_cls,
    input logic [1:0] take_lvl,
    input logic       bad_combo
);
    // R6: an impossible state never yields a take
    a_r6_bad_blocks_take: assert property (@(posedge clk) disable iff (!rst_n)
        bad_combo |-> !take_o);

    // R11: idle outputs carry the none encoding
    a_r11_idle_is_none: assert property (@(posedge clk) disable iff (!rst_n)
        !take_o |-> (take_cls == 2'b00 && take_lvl == 2'b00));

    // R9: never delivered below the level it was raised at
    a_r9_not_below: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> take_lvl >= $past(cur_lvl));

    // R10: the reported class was pending one cycle earlier
    a_r10_class_was_pending: assert property (@(posedge clk) disable iff (!rst_n)
        take_o |-> ((take_cls == 2'b01 && $past(req_irq)) ||
                    (take_cls == 2'b10 && $past(req_fiq)) ||
                    (take_cls == 2'b11 && $past(req_ser))));

    // R5: secure top-level source with wide top and no top routing stays pending
    a_r5_secure_top_pending: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(in_secure) && $past(cur_lvl) == 2'd3 && $past(has_lvl3) &&
         $past(top_wide) && !$past(top_rt_irq) && $past(req_irq) &&
         !$past(req_fiq) && !$past(req_ser)) |-> !take_o);
endmodule

bind async_exc_router async_exc_router_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_irq   (req_irq),
    .req_fiq   (req_fiq),
    .req_ser   (req_ser),
    .cur_lvl   (cur_lvl),
    .in_secure (in_secure),
    .has_lvl3  (has_lvl3),
    .top_wide  (top_wide),
    .top_rt_irq(top_rt_irq),
    .take_o    (take_o),
    .take_cls  (take_cls),
    .take_lvl  (take_lvl),
    .bad_combo (bad_combo)
);

// File: tb/async_exc_router_test.sv
module async_exc_router_test;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [2:0] pend = '0, srt = '0, hrt = '0, msk = '0;
    logic [1:0] cur = '0;
    logic sec = 0, h2 = 1, h3 = 1, wide = 1, rw = 0, tge = 0;
    logic take_o, bad_combo;
    logic [1:0] take_cls, take_lvl;
    int n_chk = 0, n_bad = 0;
    bit done = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    async_exc_router uut (
        .clk(clk), .rst_n(rst_n),
        .req_irq(pend[0]), .req_fiq(pend[1]), .req_ser(pend[2]),
        .cur_lvl(cur), .in_secure(sec), .has_lvl2(h2), .has_lvl3(h3),
        .top_wide(wide),
        .top_rt_irq(srt[0]), .top_rt_fiq(srt[1]), .top_rt_ser(srt[2]),
        .lower_wide(rw),
        .hyp_rt_irq(hrt[0]), .hyp_rt_fiq(hrt[1]), .hyp_rt_ser(hrt[2]),
        .hyp_trap_all(tge),
        .msk_irq(msk[0]), .msk_fiq(msk[1]), .msk_ser(msk[2]),
        .take_o(take_o), .take_cls(take_cls), .take_lvl(take_lvl),
        .bad_combo(bad_combo)
    );

    // expected {take, cls[1:0], lvl[1:0], bad} from the requirements
    function automatic logic [5:0] expect_out();
        logic a32, bad_st, tk, bd;
        logic [1:0] cl, lv;
        a32 = h3 && !wide;
        bad_st = sec ? (cur == 2'd2) : (cur == 2'd3);
        tk = 0; bd = 0; cl = 0; lv = 0;
        for (int c = 2; c >= 0; c--) begin
            if (pend[c] && bad_st) bd = 1;
            if (pend[c] && !bad_st && !tk) begin
                logic s, h, r, ok;
                int t;
                s = srt[c] && h3;
                h = (hrt[c] || tge) && h2;
                r = rw && !a32;
                if (s) t = 3;
                else if (sec) t = 1;
                else if (h) t = 2;
                else if (cur == 2'd2) t = r ? 1 : 2;
                else t = 1;
                if (a32 && sec && t == 1) t = 3;
                if (t < int'(cur)) ok = 0;
                else if (t > int'(cur) && t > 1) ok = 1;
                else ok = !msk[c];
                if (ok) begin
                    tk = 1; cl = 2'(c + 1); lv = 2'(t);
                end
            end
        end
        return {tk, cl, lv, bd};
    endfunction

    function automatic string tag_of();
        int np;
        np = int'(pend[0]) + int'(pend[1]) + int'(pend[2]);
        if (sec ? (cur == 2'd2) : (cur == 2'd3)) return "R6";
        if (np > 1) return "R10";
        if (!h2 || !h3 || tge) return "R7";
        if (!wide) return "R8";
        if (|(srt & pend)) return "R2";
        if (|(hrt & pend)) return "R3";
        if (sec) return "R5";
        if (|(msk & pend)) return "R9";
        return "R4";
    endfunction

    task automatic check(string tg, logic [5:0] exp);
        logic [5:0] act;
        act = {take_o, take_cls, take_lvl, bad_combo};
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: pend=%b cur=%0d sec=%0d got=%b expected=%b",
                     tg, pend, cur, sec, act, exp);
        end
    endtask

    task automatic step_check();
        logic [5:0] e;
        string tg;
        e = expect_out();
        tg = tag_of();
        @(posedge clk);
        #1;
        check(tg, e);
        @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_bad++;
        $display("FAIL watchdog: got=timeout expected=finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        // R11: reset clears outputs even with a takeable request
        pend = 3'b111; cur = 0;
        repeat (3) @(posedge clk);
        #1;
        check("R11", 6'b0);
        @(negedge clk);
        rst_n = 1;

        // R1: only the FIQ top bit set, IRQ pending -> IRQ goes to level 1
        pend = 3'b001; srt = 3'b010; cur = 1;
        step_check();
        check("R1", {1'b1, 2'b01, 2'd1, 1'b0});

        // R11: one cycle latency, output holds until next edge
        pend = 3'b000; srt = 0;
        #1;
        check("R11", {1'b1, 2'b01, 2'd1, 1'b0});
        @(posedge clk);
        #1;
        check("R11", 6'b0);
        @(negedge clk);

        // R9: masked level-1 target is not taken; bypass to level 2 is
        pend = 3'b100; msk = 3'b100; cur = 0; hrt = 0;
        step_check();
        check("R9", 6'b0);
        hrt = 3'b100;
        step_check();
        check("R9", {1'b1, 2'b11, 2'd2, 1'b0});

        // single-class exhaustive sweep
        for (int c = 0; c < 3; c++) begin
            for (int v = 0; v < 2048; v++) begin
                logic [10:0] b;
                b = 11'(v);
                pend = 3'(1 << c);
                cur = b[1:0]; sec = b[2]; h2 = b[3]; h3 = b[4]; wide = b[5];
                srt = b[6] ? 3'b111 : 3'b000; rw = b[7];
                hrt = b[8] ? 3'b111 : 3'b000; tge = b[9];
                msk = b[10] ? 3'b111 : 3'b000;
                step_check();
            end
        end

        // mixed sweep with full configuration
        h2 = 1; h3 = 1; wide = 1; rw = 0; tge = 0;
        for (int v = 0; v < 32768; v++) begin
            logic [14:0] b;
            b = 15'(v);
            pend = b[2:0]; msk = b[5:3]; cur = b[7:6]; sec = b[8];
            srt = b[11:9]; hrt = b[14:12];
            step_check();
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule